// File: doc/BRIEF.md
# Dual-Role Byte-Serial Shift Engine

A single eight-bit serial shifter for an SPI-style bus that can act as the bus controller (master) or as a responding device (slave). The role is chosen by two control inputs. The engine sets its pad output-enables to match the role. As master it divides the system clock to make the serial clock. It drives that clock and the outgoing data line, and it samples the returning data line. As slave it takes the serial clock, the incoming data line and an active-low select from outside. These pass through two-flop synchronizers. The engine then drives the returning data line while it is selected.

Clock idle level, clock phase and bit order are set by inputs. With phase 0, data is sampled on the leading clock edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge. A write through the parallel port loads the byte to send. In the master role the same write also starts the transfer. In both roles, a one-cycle done pulse marks the end of a byte and comes with the received byte. The select line of the remote device is not driven by this block.

Top module: `spi_xcvr`

## Requirements
- R1: A transfer spans exactly 16 serial clock edges (8 clock cycles). After the 16th edge, `busy` falls and `done` is high for exactly one system clock, while `rdata` holds the received byte.
- R2: In the master role the serial clock rests at `cpol` (0 gives low, 1 gives high) before and after a transfer.
- R3: Both phases work in both roles. With `cpha`=0, data is sampled on the leading (odd-numbered) edges and changed on the trailing ones. With `cpha`=1, data is changed on the leading edges and sampled on the trailing ones.
- R4: With `lsb_first`=0, bit 7 goes first and the first received bit lands in bit 7. With `lsb_first`=1, bit 0 goes first and the first received bit lands in bit 0.
- R5: With `en`=1 and `master`=1, `sck_oe` and `mosi_oe` are 1, `miso_oe` is 0, and `miso_i` is the data input.
- R6: With `en`=0 or `master`=0, `sck_oe` and `mosi_oe` are 0.
- R7: With `en`=1 and `master`=0, `mosi_i` is the data input. `miso_oe` is 1 only while the engine is selected, which means `ss_n_i` is low (after synchronization) or `ss_ignore`=1.
- R8: With `ss_ignore`=0, a slave whose `ss_n_i` is high ignores serial clock edges, so no done pulse occurs. With `ss_ignore`=1, the level of `ss_n_i` has no effect.
- R9: In the master role, a `wr` pulse while idle loads `wdata` and raises `busy` on the next clock. A `wr` while `busy` is ignored.
- R10: The first data bit is on the output line before the first serial clock edge. In the master role this happens one clock after `wr`. In the slave role it happens as soon as the engine is selected with a byte loaded.
- R11: The master serial clock half-period is `div`+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| master | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | 1 = least significant bit first |
| ss_ignore | input | 1 | 1 = slave select ignored |
| div | input | DIV_W | Half-period of master clock minus one |
| wr | input | 1 | Load `wdata`; in master role also start |
| wdata | input | 8 | Byte to transmit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-byte pulse |
| rdata | output | 8 | Last received byte |
| sck_i | input | 1 | Serial clock from pad (slave) |
| sck_o | output | 1 | Serial clock to pad (master) |
| sck_oe | output | 1 | Serial clock pad drive enable |
| mosi_i | input | 1 | Controller-out line from pad (slave) |
| mosi_o | output | 1 | Controller-out line to pad (master) |
| mosi_oe | output | 1 | Controller-out pad drive enable |
| miso_i | input | 1 | Device-out line from pad (master) |
| miso_o | output | 1 | Device-out line to pad (slave) |
| miso_oe | output | 1 | Device-out pad drive enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The assertions check on every cycle that the done pulse lasts one clock and never coincides with `busy`, and that the master clock sits at its idle level when a transfer begins and when it completes. They also check that an enabled slave with select ignored keeps driving its output line. The bench scenarios alone show the exchange itself: the bit sequence on both data lines for every phase, polarity and bit-order combination in both roles, the half-period length, the rejection of a write during a transfer, and the suppression of a transfer when the slave is not selected.

// File: rtl/spi_xcvr.sv
module spi_xcvr #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             master,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic             ss_ignore,
  input  logic [DIV_W-1:0] div,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rdata,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             ss_n_i
);

  logic [2:0]       sck_s;
  logic [1:0]       mosi_s, ss_s;
  logic [DIV_W-1:0] cnt;
  logic [3:0]       ecnt;
  logic [7:0]       tx, rx;
  logic             sck_q;

  wire m_role = en & master;
  wire s_role = en & ~master;
  wire s_sel  = ss_ignore | ~ss_s[1];

  wire s_edge = s_role & s_sel & (sck_s[2] ^ sck_s[1]) &
                ((ecnt != 4'd0) | (sck_s[1] != cpol));
  wire m_tick = m_role & busy & (cnt == div);
  wire ev     = m_tick | s_edge;

  wire lead   = ~ecnt[0];
  wire samp   = ev & (lead ^ cpha);
  wire shft   = ev & ~(lead ^ cpha) & (cpha ? (ecnt != 4'd0) : (ecnt != 4'd15));

  wire       rx_bit = master ? miso_i : mosi_s[1];
  wire [7:0] rx_nx  = lsb_first ? {rx_bit, rx[7:1]} : {rx[6:0], rx_bit};
  wire [7:0] tx_nx  = lsb_first ? {1'b0, tx[7:1]} : {tx[6:0], 1'b0};
  wire       out_bit = lsb_first ? tx[0] : tx[7];

  assign sck_o   = sck_q;
  assign sck_oe  = m_role;
  assign mosi_o  = out_bit;
  assign mosi_oe = m_role;
  assign miso_o  = out_bit;
  assign miso_oe = s_role & s_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
      ss_s   <= 2'b11;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      mosi_s <= {mosi_s[0], mosi_i};
      ss_s   <= {ss_s[0], ss_n_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rdata <= '0;
      tx    <= '0;
      rx    <= '0;
      ecnt  <= '0;
      cnt   <= '0;
      sck_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy)
        sck_q <= cpol;
      if (!en || (s_role && !s_sel)) begin
        busy <= 1'b0;
        ecnt <= '0;
        cnt  <= '0;
      end else if (ev) begin
        ecnt <= ecnt + 4'd1;
        cnt  <= '0;
        if (master)
          sck_q <= ~sck_q;
        if (samp)
          rx <= rx_nx;
        if (shft)
          tx <= tx_nx;
        if (ecnt == 4'd15) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          rdata <= samp ? rx_nx : rx;
        end else begin
          busy <= 1'b1;
        end
      end else if (m_role && busy) begin
        cnt <= cnt + 1'b1;
      end
      if (wr && !busy) begin
        tx <= wdata;
        if (m_role) begin
          busy <= 1'b1;
          cnt  <= '0;
          ecnt <= '0;
        end
      end
    end
  end

endmodule

module spi_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic master,
  input logic cpol,
  input logic ss_ignore,
  input logic busy,
  input logic done,
  input logic sck_o,
  input logic miso_oe
);

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && $rose(busy) && $stable(cpol)) |-> (sck_o == cpol));

  // R2
  end_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && done && $stable(cpol)) |-> (sck_o == cpol));

  // R8
  ignore_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !master && ss_ignore && busy) |-> miso_oe);

endmodule

bind spi_xcvr spi_xcvr_chk u_spi_xcvr_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol),
  .ss_ignore(ss_ignore), .busy(busy), .done(done), .sck_o(sck_o),
  .miso_oe(miso_oe)
);

// File: tb/test_spi_xcvr.sv
module test_spi_xcvr;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, master = 0, cpol = 0, cpha = 0, lsb_first = 0, ss_ignore = 0;
  logic [7:0] div = 8'd3;
  logic wr = 0;
  logic [7:0] wdata = '0;
  logic busy, done;
  logic [7:0] rdata;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int nvec = 0, nbad = 0;
  int done_cnt = 0;
  logic [7:0] last_rdata = '0;

  always #4 clk = ~clk;

  spi_xcvr #(.DIV_W(8)) i_spi_xcvr (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol),
    .cpha(cpha), .lsb_first(lsb_first), .ss_ignore(ss_ignore), .div(div),
    .wr(wr), .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  always @(negedge clk) if (done) begin
    done_cnt   <= done_cnt + 1;
    last_rdata <= rdata;
  end

  function automatic logic bitseq(logic [7:0] b, logic lf, int i);
    return lf ? b[i] : b[7-i];
  endfunction

  function automatic logic [7:0] assemble(logic [7:0] c, logic lf);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      if (lf) r[i] = c[i]; else r[7-i] = c[i];
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  task automatic master_xfer(input logic [7:0] m, input logic [7:0] s,
                             input logic cp, input logic ph, input logic lf,
                             input logic [7:0] dv, input logic inject);
    logic [7:0] capv = '0;
    int ci = 0;
    time t1 = 0, t2 = 0;
    en = 1; master = 1; cpol = cp; cpha = ph; lsb_first = lf; div = dv;
    miso_i = bitseq(s, lf, 0);
    repeat (3) @(negedge clk);
    chk(sck_o == cp, "R2 idle before", sck_o, cp);
    chk(sck_oe && mosi_oe && !miso_oe, "R5 pad enables", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    done_cnt = 0;
    fork
      begin
        wr = 1; wdata = m;
        @(negedge clk);
        wr = 0;
        chk(busy == 1'b1, "R9 busy after write", busy, 1);
        chk(mosi_o == bitseq(m, lf, 0), "R10 master first bit", mosi_o, bitseq(m, lf, 0));
        if (inject) begin
          repeat (3) @(negedge clk);
          wr = 1; wdata = ~m;
          @(negedge clk);
          wr = 0;
        end
        for (int k = 0; k < 3000 && done_cnt == 0; k++) @(negedge clk);
      end
      begin
        for (int e = 1; e <= 16; e++) begin
          @(sck_o);
          #1;
          if (e == 1) t1 = $time;
          if (e == 2) t2 = $time;
          if ((e % 2 == 1) != ph) begin
            capv[ci] = mosi_o;
            ci++;
          end else begin
            int idx = ph ? (e - 1) / 2 : e / 2;
            if (idx >= 1 && idx <= 7) miso_i = bitseq(s, lf, idx);
          end
        end
      end
    join
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R1 one done pulse", done_cnt, 1);
    chk(busy == 1'b0, "R1 busy cleared", busy, 0);
    chk(last_rdata == s, "R3 master receive", last_rdata, s);
    chk(assemble(capv, lf) == m, inject ? "R9 write while busy ignored" : "R4 master send order",
        assemble(capv, lf), m);
    chk(sck_o == cp, "R2 idle after", sck_o, cp);
    chk((t2 - t1) == (dv + 1) * 8, "R11 half period", int'(t2 - t1), (dv + 1) * 8);
  endtask

  task automatic slave_xfer(input logic [7:0] m, input logic [7:0] s,
                            input logic cp, input logic ph, input logic lf,
                            input logic use_ss);
    logic [7:0] capv = '0;
    int ci = 0;
    en = 1; master = 0; cpol = cp; cpha = ph; lsb_first = lf; ss_ignore = !use_ss;
    ss_n_i = 1; sck_i = cp; mosi_i = 0;
    repeat (4) @(negedge clk);
    chk(!sck_oe && !mosi_oe, "R6 slave releases clock/data", {sck_oe, mosi_oe}, 0);
    wr = 1; wdata = s;
    @(negedge clk);
    wr = 0;
    if (use_ss) ss_n_i = 0;
    repeat (4) @(negedge clk);
    chk(miso_oe == 1'b1, use_ss ? "R7 selected drives" : "R8 select ignored", miso_oe, 1);
    if (!ph) chk(miso_o == bitseq(s, lf, 0), "R10 slave first bit", miso_o, bitseq(s, lf, 0));
    done_cnt = 0;
    if (!ph) mosi_i = bitseq(m, lf, 0);
    for (int e = 1; e <= 16; e++) begin
      repeat (8) @(negedge clk);
      if ((e % 2 == 1) != ph) begin
        capv[ci] = miso_o;
        ci++;
      end
      sck_i = ~sck_i;
      if ((e % 2 == 1) == ph) begin
        int idx = ph ? (e - 1) / 2 : e / 2;
        if (idx <= 7) mosi_i = bitseq(m, lf, idx);
      end
    end
    repeat (8) @(negedge clk);
    chk(done_cnt == 1, "R1 slave done pulse", done_cnt, 1);
    chk(last_rdata == m, "R3 slave receive", last_rdata, m);
    chk(assemble(capv, lf) == s, "R4 slave send order", assemble(capv, lf), s);
    ss_n_i = 1;
    repeat (4) @(negedge clk);
    if (use_ss) chk(miso_oe == 1'b0, "R7 deselected releases", miso_oe, 0);
  endtask

  task automatic deselected_slave(input logic cp);
    en = 1; master = 0; cpol = cp; cpha = 0; ss_ignore = 0; ss_n_i = 1; sck_i = cp;
    repeat (4) @(negedge clk);
    done_cnt = 0;
    for (int e = 1; e <= 16; e++) begin
      repeat (8) @(negedge clk);
      sck_i = ~sck_i;
    end
    repeat (8) @(negedge clk);
    chk(done_cnt == 0, "R8 deselected ignores clock", done_cnt, 0);
    chk(miso_oe == 1'b0, "R8 deselected no drive", miso_oe, 0);
    chk(busy == 1'b0, "R8 deselected not busy", busy, 0);
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    chk(busy == 0 && done == 0 && rdata == 0, "R1 reset state", {busy, done, rdata}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!sck_oe && !mosi_oe && !miso_oe, "R6 disabled releases pads",
        {sck_oe, mosi_oe, miso_oe}, 0);

    for (int c = 0; c < 8; c++)
      master_xfer(8'hA5 ^ 8'(c), 8'h3C ^ 8'(c * 17), c[0], c[1], c[2], 8'd1, 1'b0);
    master_xfer(8'h80, 8'h01, 0, 0, 0, 8'd0, 1'b0);
    master_xfer(8'hFF, 8'h00, 1, 1, 1, 8'd7, 1'b1);
    for (int c = 0; c < 8; c++)
      slave_xfer(8'h96 ^ 8'(c * 5), 8'h5A ^ 8'(c), c[0], c[1], c[2], c[0] ^ c[1]);
    deselected_slave(0);
    deselected_slave(1);

    for (int n = 0; n < 20; n++) begin
      logic [31:0] r = $urandom;
      master_xfer(8'($urandom), 8'($urandom), r[0], r[1], r[2], 8'(1 + r[5:3] % 6), r[6]);
    end
    for (int n = 0; n < 20; n++) begin
      logic [31:0] r = $urandom;
      slave_xfer(8'($urandom), 8'($urandom), r[0], r[1], r[2], r[3]);
    end

    en = 0;
    repeat (2) @(negedge clk);
    chk(!sck_oe && !mosi_oe && !miso_oe, "R6 disabled at end",
        {sck_oe, mosi_oe, miso_oe}, 0);
    summary();
  end

endmodule